// File: doc/BRIEF.md
# Programmable Event-Count Delay Counter

This block waits for a programmed number of event strobes after a start strobe, then raises a one-clock done pulse. The delay is given as a row of BCD digits, five by default. Each decade counter starts at the nines' complement of its digit: a digit d loads 9 − d. From there the cascade counts up on each accepted event. The delay ends when every decade holds 9.

Once done, the block reloads every decade from the preset digits and closes its event gate. The next delay cycle then waits for a new start strobe. The block therefore suits repeated delay measurements against a count setting that changes rarely. Software or panel logic only has to hold the digits and pulse start.

Top module: `evc_delay_counter`

## Requirements
- R1: A cycle with `rst` high loads every decade with its complemented preset, clears `done_o` and closes the event gate. These values are visible in the following cycle.
- R2: Decade i (bits 4i+3..4i of `preset_i` and `count_o`, with decade 0 least significant) loads 9 minus its preset digit. A preset digit above 9 is taken as 9 and loads 0.
- R3: While the gate is closed, `event_i` has no effect on `count_o`.
- R4: A `start_i` strobe opens the gate from the next cycle. An event in the same cycle as the opening start is not counted.
- R5: An event while the gate is open increments the BCD value on `count_o` by one in the next cycle. A decade passing 9 returns to 0 and increments the next decade up. Every digit always stays within 0 to 9.
- R6: `done_o` is high for exactly one cycle, the first cycle in which `count_o` reads all nines after an increment. This happens after exactly P accepted events, where P is the preset value; a preset of 0 needs 100000 events by wrapping.
- R7: In the cycle `done_o` is high, `start_i` and `event_i` are ignored. On the next cycle every decade holds the complement of the preset sampled in the done cycle, and the gate is closed.
- R8: After a reload, events have no effect until a new start strobe arrives, so each delay cycle needs its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset strobe, active high |
| start_i | input | 1 | Start strobe that opens the event gate |
| event_i | input | 1 | Event strobe to be counted |
| preset_i | input | 20 | Preset digits, four bits per decade, decade 0 in the low bits |
| done_o | output | 1 | One-cycle pulse at the end of a delay |
| count_o | output | 20 | Present BCD contents of the decades |

## Verification
The assertions assume that `rst` is high in the first cycle, which puts every decade in a legal BCD state. They also assume that `start_i`, `event_i` and `rst` are sampled only at rising edges; a preset digit may take any four-bit value. The stimulus meets these assumptions in three ways. It starts with a reset. It drives every strobe on the falling edge, one cycle at a time. It applies out-of-range digits only through the preset inputs, where the clamp rule defines the result.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
package evc_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] bcd_t;

    // Value loaded into a decade for a switch digit, clamped to 9 first.
    function automatic bcd_t nines_comp(input bcd_t sw);
        bcd_t clamped;
        clamped = (sw > 4'd9) ? 4'd9 : sw;
        return 4'd9 - clamped;
    endfunction
endpackage

// File: rtl/evc_preset_comp.sv
`timescale 1ns/1ps
module evc_preset_comp
    import evc_pkg::*;
(
    input  bcd_t sw_i,
    output bcd_t comp_o
);
    always_comb begin
        comp_o = nines_comp(sw_i);
    end
endmodule

// File: rtl/evc_decade.sv
`timescale 1ns/1ps
module evc_decade
    import evc_pkg::*;
(
    input  bcd_t digit_i,
    input  logic carry_i,
    output bcd_t digit_o,
    output logic carry_o
);
    logic at_nine;

    always_comb begin
        at_nine = (digit_i == 4'd9);
        carry_o = carry_i & at_nine;
        if (!carry_i)
            digit_o = digit_i;
        else if (at_nine)
            digit_o = '0;
        else
            digit_o = digit_i + 4'd1;
    end
endmodule

// File: rtl/evc_delay_counter.sv
`timescale 1ns/1ps
module evc_delay_counter
    import evc_pkg::*;
#(
    parameter int NUM_DIGITS = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic                          event_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] preset_i,
    output logic                          done_o,
    output logic [NUM_DIGITS*DIGIT_W-1:0] count_o
);
    localparam int CW = NUM_DIGITS * DIGIT_W;

    typedef struct packed {
        logic [CW-1:0] count;
        logic          gate;
        logic          done;
    } state_t;

    state_t s_d, s_q;

    logic [CW-1:0]         reload_val;
    logic [CW-1:0]         inc_val;
    logic [NUM_DIGITS:0]   carry;
    logic [NUM_DIGITS-1:0] inc_nine;
    logic                  inc_all_nines;
    logic                  cur_all_nines;
    logic                  accept;

    assign carry[0] = 1'b1;

    // One complement stage and one decade stage per digit.
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dec
        evc_preset_comp u_comp (
            .sw_i   (preset_i[i*DIGIT_W +: DIGIT_W]),
            .comp_o (reload_val[i*DIGIT_W +: DIGIT_W])
        );
        evc_decade u_dec (
            .digit_i (s_q.count[i*DIGIT_W +: DIGIT_W]),
            .carry_i (carry[i]),
            .digit_o (inc_val[i*DIGIT_W +: DIGIT_W]),
            .carry_o (carry[i+1])
        );
        assign inc_nine[i] = (inc_val[i*DIGIT_W +: DIGIT_W] == 4'd9);
    end

    // Carry out of the top with carry-in forced high means every decade is at 9.
    assign cur_all_nines = carry[NUM_DIGITS];
    assign inc_all_nines = &inc_nine;
    assign accept        = s_q.gate & event_i & ~s_q.done;

    always_comb begin
        s_d = s_q;
        if (rst || s_q.done) begin
            s_d.count = reload_val;
            s_d.gate  = 1'b0;
            s_d.done  = 1'b0;
        end else begin
            s_d.gate = s_q.gate | start_i;
            s_d.done = 1'b0;
            if (accept) begin
                s_d.count = inc_val;
                s_d.done  = inc_all_nines;
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign done_o  = s_q.done;
    assign count_o = s_q.count;

    // R6: done lasts one cycle and only coincides with an all-nines count
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        s_q.done |=> !s_q.done);
    p_done_nines_r6: assert property (@(posedge clk) disable iff (rst)
        s_q.done |-> cur_all_nines);

    // R7: the cycle after done the gate is closed
    p_reload_gate_r7: assert property (@(posedge clk) disable iff (rst)
        s_q.done |=> !s_q.gate);

    // R3: a closed gate freezes the count outside the reload
    p_gate_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!s_q.gate && !s_q.done) |=> $stable(s_q.count));

    // R4: start opens the gate on the next cycle
    p_start_open_r4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !s_q.done) |=> s_q.gate);

    // R5: no event, no change while counting
    p_no_event_r5: assert property (@(posedge clk) disable iff (rst)
        (!event_i && !s_q.done) |=> $stable(s_q.count));

    // R5: every decade stays a legal BCD digit
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_chk
        p_bcd_digit_r5: assert property (@(posedge clk) disable iff (rst)
            s_q.count[k*DIGIT_W +: DIGIT_W] <= 4'd9);
    end
endmodule

// File: tb/evc_delay_counter_tb.sv
`timescale 1ns/1ps
module evc_delay_counter_tb;
    localparam int ND = 5;
    localparam int CW = ND * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          event_i = 1'b0;
    logic [CW-1:0] preset_i = '0;
    logic          done_o;
    logic [CW-1:0] count_o;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    // Reference model state
    int m_cnt  = 0;
    bit m_gate = 0;
    bit m_done = 0;

    always #4 clk = ~clk;

    evc_delay_counter #(.NUM_DIGITS(ND)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .event_i (event_i),
        .preset_i(preset_i),
        .done_o  (done_o),
        .count_o (count_o)
    );

    function automatic int bcd2int(input logic [CW-1:0] v);
        int r = 0;
        int w = 1;
        for (int i = 0; i < ND; i++) begin
            r = r + int'(v[i*4 +: 4]) * w;
            w = w * 10;
        end
        return r;
    endfunction

    function automatic int start_value(input logic [CW-1:0] p);
        int r = 0;
        int w = 1;
        for (int i = 0; i < ND; i++) begin
            int d = int'(p[i*4 +: 4]);
            if (d > 9) d = 9;
            r = r + (9 - d) * w;
            w = w * 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, compare just after.
    task automatic step(input bit st, input bit ev, input bit r);
        int legal;
        @(negedge clk);
        start_i = st;
        event_i = ev;
        rst     = r;
        @(posedge clk);
        if (r || m_done) begin
            m_cnt  = start_value(preset_i);
            m_gate = 0;
            m_done = 0;
        end else begin
            bit ng = m_gate | st;
            m_done = 0;
            if (m_gate && ev) begin
                m_cnt  = (m_cnt + 1) % 100000;
                m_done = (m_cnt == 99999);
            end
            m_gate = ng;
        end
        #1;
        legal = 1;
        for (int i = 0; i < ND; i++)
            if (count_o[i*4 +: 4] > 4'd9) legal = 0;
        check(legal == 1, "R5 digit range", legal, 1);
        check(bcd2int(count_o) == m_cnt, cur_req, bcd2int(count_o), m_cnt);
        check(done_o == m_done, {cur_req, " done"}, int'(done_o), int'(m_done));
    endtask

    task automatic run_to_done(input int expect_n, input string req);
        int n = 0;
        do begin
            step(0, 1, 0);
            n++;
        end while (!done_o && n < 120000);
        check(n == expect_n, req, n, expect_n);
        check(bcd2int(count_o) == 99999, req, bcd2int(count_o), 99999);
    endtask

    initial begin
        #1500000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1, R2: reset loads complements (00012 -> 99987)
        preset_i = 20'h00012;
        cur_req = "R1";
        step(0, 0, 1);
        check(bcd2int(count_o) == 99987, "R1 reset count", bcd2int(count_o), 99987);
        check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);

        // R3: events with the gate closed are ignored
        cur_req = "R3";
        for (int i = 0; i < 5; i++) step(0, 1, 0);
        check(bcd2int(count_o) == 99987, "R3 closed gate", bcd2int(count_o), 99987);

        // R4: start together with an event does not count that event
        cur_req = "R4";
        step(1, 1, 0);
        check(bcd2int(count_o) == 99987, "R4 start+event", bcd2int(count_o), 99987);
        step(0, 1, 0);
        check(bcd2int(count_o) == 99988, "R4 first counted", bcd2int(count_o), 99988);

        // R6: done after remaining 11 events (12 in total)
        cur_req = "R6";
        run_to_done(11, "R6 event count");

        // R7: start and event in the done cycle are ignored; the new preset is sampled
        cur_req = "R7";
        preset_i = 20'h00105;
        step(1, 1, 0);
        check(bcd2int(count_o) == 99894, "R7 reload", bcd2int(count_o), 99894);
        check(done_o == 1'b0, "R7 done cleared", int'(done_o), 0);

        // R8: no counting until a new start
        cur_req = "R8";
        for (int i = 0; i < 3; i++) step(0, 1, 0);
        check(bcd2int(count_o) == 99894, "R8 needs start", bcd2int(count_o), 99894);
        step(1, 0, 0);
        cur_req = "R5";
        run_to_done(105, "R5 cascade 105");
        step(0, 0, 0);

        // R5: longer cascade through several decades
        preset_i = 20'h01000;
        step(0, 0, 1);
        check(bcd2int(count_o) == 98999, "R5 reset 01000", bcd2int(count_o), 98999);
        step(1, 0, 0);
        run_to_done(1000, "R5 cascade 1000");
        step(0, 0, 0);

        // R2: digits above 9 clamp to 9 (0,0,0,F,A -> 00099 -> 99900)
        cur_req = "R2";
        preset_i = 20'h000FA;
        step(0, 0, 1);
        check(bcd2int(count_o) == 99900, "R2 clamp", bcd2int(count_o), 99900);
        step(1, 0, 0);
        run_to_done(99, "R2 clamp delay");

        // R6: gaps between events and a mid-cycle start do not disturb the count
        cur_req = "R6";
        step(0, 0, 0);
        step(1, 0, 0);
        for (int i = 0; i < 40; i++) step((i % 7) == 3, (i % 3) != 0, 0);
        step(0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule